// File: doc/BRIEF.md
# Serial Register Port with Data-Ready Handshake

This block is the slave side of a four-wire serial link for a converter-style device. A master drives chip select, serial clock and data in. The block answers on data out and an output enable. Through this link the master writes and reads a bank of 8-bit configuration registers and fetches a 24-bit conversion word. The clock and select lines are oversampled in the system clock domain through two-flop synchronisers, so the system clock must run at least 8 times faster than the serial clock. A polarity pin sets the idle level of the serial clock. The first edge away from idle samples data in, and the return edge launches data out. Because of this the bit format is the same for both polarities.

Every transaction is self-framed by a command byte sent MSB first:
- `00xx_aaaa` writes the following byte to register `aaaa`.
- `1xxx_aaaa` returns register `aaaa` in the following byte.
- `01xx_xxxx` streams the 24-bit conversion word MSB first.

After each of these the port expects a new command. Commands can therefore follow one another with no gap and with chip select held low, which is three-wire operation. A rising chip select drops any partial byte.

A result strobe from the converter side stands in for new conversions. The active-low data-ready output rises on the strobe and stays high for two system cycles. The data register is then loaded and data-ready falls. Data-ready rises again once a full 24-bit stream read has finished. If a stream read is under way, the load waits until it ends. The data-ready level can also be polled as bit 7 of register 0.

Top module: `spi_dready_port`

## Requirements
- R1: After reset, `drdy_n` is 1, `sdo_oe` is 0 and every byte of `cfg_regs` is 0.
- R2: While chip select is high, `sdo_oe` and `sdo` stay 0, and clock and data activity on the bus changes no register.
- R3: A write command `{4'b0000, addr}` followed by a data byte stores the byte, and it shows in `cfg_regs[addr*8 +: 8]`. A read command `{4'b1000, addr}` returns that byte MSB first on `sdo` during the next byte.
- R4: With `clk_pol`=0, data in is sampled on the rising serial clock edge and data out changes on the falling edge. With `clk_pol`=1 the edges swap. Reads and writes give the same results under both settings.
- R5: Register 0 bits 6:0 are writable. A read of register 0 returns the current `drdy_n` level in bit 7. A write to bit 7 is ignored, so `cfg_regs[7]` stays 0.
- R6: The command `8'h40` streams the 24-bit data register MSB first over the next three bytes, and the port then expects a new command.
- R7: A strobe on `res_valid` sampled at clock edge k drives `drdy_n` high after edge k. It stays high after edge k+1. The data register loads at edge k+2, and `drdy_n` is low after it.
- R8: `drdy_n` goes high once the 24th data bit of a stream read has been sampled.
- R9: While a stream read is in progress, a pending result is not loaded. The stream returns the old word intact, and the new word lands right after the read ends.
- R10: Any number of commands may follow each other with chip select held low throughout.
- R11: A rising chip select in the middle of a byte discards it: a cut-off write changes nothing, and a cut-off stream read leaves `drdy_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_pol | input | 1 | Serial clock idle level (0 low, 1 high) |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data out of the block |
| sdo_oe | output | 1 | Output enable for `sdo`, high while selected |
| res_valid | input | 1 | One-cycle strobe for a new conversion result |
| res_data | input | 24 | Conversion result carried with the strobe |
| drdy_n | output | 1 | Active-low data-ready |
| cfg_regs | output | 128 | Contents of the 16 configuration registers, register n at bits n*8+7:n*8 |

## Verification
The hardest state to reach from the ports is a result strobe that arrives while the master is part-way through a stream read. The update must be held off at that point, and the stream must still return the old word. The bench creates this case by splitting a stream read into single bytes and firing the strobe between the first and second byte. It then compares the remaining bits with the old word, checks that `drdy_n` falls at once after the last bit, and checks that a second stream returns the new word. A similar split is used to cut a stream read and a write short with chip select, which shows that partial bytes are dropped.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_WDAT = 2'd1,
    PH_RDAT = 2'd2
  } phase_t;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_pol,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic samp_p,
  output logic launch_p,
  output logic sdi_s,
  output logic sel
);
  logic [STAGES:0]   sclk_q, sclk_d;
  logic [STAGES-1:0] cs_q, cs_d;
  logic [STAGES-1:0] sdi_q, sdi_d;
  logic rise, fall;

  always_comb begin
    sclk_d = {sclk_q[STAGES-1:0], sclk};
    cs_d   = {cs_q[STAGES-2:0], cs_n};
    sdi_d  = {sdi_q[STAGES-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      sdi_q  <= '0;
    end else begin
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      sdi_q  <= sdi_d;
    end
  end

  always_comb begin
    rise     = sclk_q[STAGES-1] & ~sclk_q[STAGES];
    fall     = ~sclk_q[STAGES-1] & sclk_q[STAGES];
    samp_p   = clk_pol ? fall : rise;
    launch_p = clk_pol ? rise : fall;
    sdi_s    = sdi_q[STAGES-1];
    sel      = ~cs_q[STAGES-1];
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_dr_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_p,
  input  logic              launch_p,
  input  logic              sdi_s,
  input  logic              sel,
  input  logic [REG_W-1:0]  reg_rval,
  input  logic [DATA_W-1:0] dor,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [REG_W-1:0]  wr_data,
  output logic              stream_busy,
  output logic              stream_done,
  output logic              sdo
);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int RD_BIT = REG_W - 1;
  localparam int ST_BIT = REG_W - 2;

  phase_t              phase_q, phase_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d, len_q, len_d;
  logic [REG_W-1:0]    in_q, in_d, in_next;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [DATA_W-1:0]   out_q, out_d;
  logic                sdo_q, sdo_d, busy_q, busy_d, start;

  always_comb begin
    in_next     = {in_q[REG_W-2:0], sdi_s};
    rd_addr     = in_next[ADDR_W-1:0];
    phase_d     = phase_q;
    cnt_d       = cnt_q;
    len_d       = len_q;
    in_d        = in_q;
    addr_d      = addr_q;
    out_d       = out_q;
    sdo_d       = sdo_q;
    busy_d      = busy_q;
    wr_en       = 1'b0;
    stream_done = 1'b0;
    start       = 1'b0;
    if (!sel) begin
      phase_d = PH_CMD;
      cnt_d   = '0;
      in_d    = '0;
      out_d   = '0;
      sdo_d   = 1'b0;
      busy_d  = 1'b0;
    end else begin
      if (launch_p) begin
        sdo_d = out_q[DATA_W-1];
        out_d = {out_q[DATA_W-2:0], 1'b0};
      end
      if (samp_p) begin
        in_d  = in_next;
        cnt_d = cnt_q + 1'b1;
        unique case (phase_q)
          PH_CMD: if (cnt_q == CNT_W'(REG_W - 1)) begin
            cnt_d  = '0;
            addr_d = in_next[ADDR_W-1:0];
            if (in_next[RD_BIT]) begin
              phase_d = PH_RDAT;
              len_d   = CNT_W'(REG_W);
              out_d   = {reg_rval, {(DATA_W-REG_W){1'b0}}};
            end else if (in_next[ST_BIT]) begin
              phase_d = PH_RDAT;
              len_d   = CNT_W'(DATA_W);
              out_d   = dor;
              busy_d  = 1'b1;
              start   = 1'b1;
            end else begin
              phase_d = PH_WDAT;
            end
          end
          PH_WDAT: if (cnt_q == CNT_W'(REG_W - 1)) begin
            cnt_d   = '0;
            wr_en   = 1'b1;
            phase_d = PH_CMD;
          end
          PH_RDAT: if (cnt_q == len_q - 1'b1) begin
            cnt_d   = '0;
            phase_d = PH_CMD;
            if (busy_q) begin
              busy_d      = 1'b0;
              stream_done = 1'b1;
            end
          end
          default: phase_d = PH_CMD;
        endcase
      end
    end
    wr_addr     = addr_q;
    wr_data     = in_next;
    stream_busy = busy_q | start;
    sdo         = sdo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      len_q   <= '0;
      in_q    <= '0;
      addr_q  <= '0;
      out_q   <= '0;
      sdo_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      in_q    <= in_d;
      addr_q  <= addr_d;
      out_q   <= out_d;
      sdo_q   <= sdo_d;
      busy_q  <= busy_d;
    end
  end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int NREG     = 16,
  parameter int REG_W    = 8,
  parameter int ADDR_W   = 4,
  parameter int STAT_BIT = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [REG_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic                  status_in,
  output logic [REG_W-1:0]      rd_val,
  output logic [NREG*REG_W-1:0] cfg_flat
);
  logic [REG_W-1:0] reg_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [REG_W-1:0] KEEP =
      (g == 0) ? ~(REG_W'(1) << STAT_BIT) : {REG_W{1'b1}};
    logic hit;
    logic [REG_W-1:0] reg_d;

    always_comb begin
      hit   = wr_en && (wr_addr == ADDR_W'(g));
      reg_d = hit ? (wr_data & KEEP) : reg_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[g] <= '0;
      else        reg_q[g] <= reg_d;
    end

    assign cfg_flat[g*REG_W +: REG_W] = reg_q[g];
  end

  always_comb begin
    rd_val = reg_q[rd_addr];
    if (rd_addr == '0) rd_val[STAT_BIT] = status_in;
  end
endmodule

// File: rtl/spi_drdy_ctrl.sv
module spi_drdy_ctrl #(
  parameter int DATA_W = 24,
  parameter int LEAD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              stream_busy,
  input  logic              stream_done,
  output logic [DATA_W-1:0] dor,
  output logic              drdy_n,
  output logic              dor_load
);
  localparam int WAIT_W = $clog2(LEAD + 1);

  logic [DATA_W-1:0] stage_q, stage_d, dor_q, dor_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              pend_q, pend_d, drdy_q, drdy_d;

  always_comb begin
    stage_d  = stage_q;
    dor_d    = dor_q;
    wait_d   = wait_q;
    pend_d   = pend_q;
    drdy_d   = drdy_q;
    dor_load = 1'b0;
    if (stream_done) drdy_d = 1'b1;
    if (pend_q) begin
      if (wait_q != WAIT_W'(LEAD - 1)) begin
        wait_d = wait_q + 1'b1;
      end else if (!stream_busy) begin
        dor_load = 1'b1;
        dor_d    = stage_q;
        drdy_d   = 1'b0;
        pend_d   = 1'b0;
      end
    end
    if (res_valid) begin
      stage_d = res_data;
      pend_d  = 1'b1;
      wait_d  = '0;
      drdy_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      dor_q   <= '0;
      wait_q  <= '0;
      pend_q  <= 1'b0;
      drdy_q  <= 1'b1;
    end else begin
      stage_q <= stage_d;
      dor_q   <= dor_d;
      wait_q  <= wait_d;
      pend_q  <= pend_d;
      drdy_q  <= drdy_d;
    end
  end

  assign dor    = dor_q;
  assign drdy_n = drdy_q;
endmodule

// File: rtl/spi_dready_port.sv
module spi_dready_port #(
  parameter int NREG   = 16,
  parameter int REG_W  = 8,
  parameter int DATA_W = 24,
  parameter int LEAD   = 2,
  parameter int STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clk_pol,
  input  logic                  cs_n,
  input  logic                  sclk,
  input  logic                  sdi,
  output logic                  sdo,
  output logic                  sdo_oe,
  input  logic                  res_valid,
  input  logic [DATA_W-1:0]     res_data,
  output logic                  drdy_n,
  output logic [NREG*REG_W-1:0] cfg_regs
);
  localparam int ADDR_W = $clog2(NREG);

  logic samp_p, launch_p, sdi_s, sel;
  logic wr_en, stream_busy, stream_done, dor_load;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [REG_W-1:0]  wr_data, reg_rval;
  logic [DATA_W-1:0] dor;

  spi_edge_sync #(.STAGES(STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .clk_pol(clk_pol), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdi), .samp_p(samp_p), .launch_p(launch_p),
    .sdi_s(sdi_s), .sel(sel)
  );

  spi_cmd_engine #(.REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_eng (
    .clk(clk), .rst_n(rst_n), .samp_p(samp_p), .launch_p(launch_p),
    .sdi_s(sdi_s), .sel(sel), .reg_rval(reg_rval), .dor(dor),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stream_busy(stream_busy), .stream_done(stream_done), .sdo(sdo)
  );

  spi_reg_bank #(.NREG(NREG), .REG_W(REG_W), .ADDR_W(ADDR_W), .STAT_BIT(REG_W-1)) i_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .status_in(drdy_n),
    .rd_val(reg_rval), .cfg_flat(cfg_regs)
  );

  spi_drdy_ctrl #(.DATA_W(DATA_W), .LEAD(LEAD)) i_drdy (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .stream_busy(stream_busy), .stream_done(stream_done),
    .dor(dor), .drdy_n(drdy_n), .dor_load(dor_load)
  );

  assign sdo_oe = sel;
endmodule

// File: rtl/spi_dready_port_chk.sv
module spi_dready_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sdo,
  input logic sdo_oe,
  input logic res_valid,
  input logic drdy_n,
  input logic stream_busy,
  input logic stream_done,
  input logic dor_load
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R2
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  // R2
  desel_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !sdo_oe);

  // R7
  strobe_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> drdy_n);

  // R7
  load_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dor_load |-> drdy_n);

  // R7
  load_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dor_load && !res_valid) |=> !drdy_n);

  // R8
  read_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stream_done |=> drdy_n);

  // R9
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stream_busy |-> !dor_load);
endmodule

bind spi_dready_port spi_dready_port_chk i_chk (.*);

// File: tb/test_spi_dready_port.sv
`timescale 1ns/1ps
module test_spi_dready_port;
  localparam int HALF = 8;

  logic clk, rst_n, clk_pol, cs_n, sclk, sdi, res_valid;
  logic [23:0] res_data;
  logic sdo, sdo_oe, drdy_n;
  logic [127:0] cfg_regs;

  int n_chk, n_fail;
  bit done;
  logic [7:0] model [16];

  spi_dready_port i_spi_dready_port (
    .clk(clk), .rst_n(rst_n), .clk_pol(clk_pol), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .res_valid(res_valid),
    .res_data(res_data), .drdy_n(drdy_n), .cfg_regs(cfg_regs)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] exp_rd(input int a, input logic dr);
    if (a == 0) return {dr, model[0][6:0]};
    return model[a];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk);
      sdi = tx[i];
      repeat (HALF) @(negedge clk);
      rx = {rx[6:0], sdo};
      sclk = ~clk_pol;
      repeat (HALF) @(negedge clk);
      sclk = clk_pol;
    end
  endtask

  task automatic sel_on();
    @(negedge clk);
    sclk = clk_pol;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sel_off();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_reg(input int a, input logic [7:0] d);
    logic [7:0] rx;
    shift_bits({4'b0000, 4'(a)}, 8, rx);
    shift_bits(d, 8, rx);
    model[a] = (a == 0) ? {1'b0, d[6:0]} : d;
  endtask

  task automatic rd_reg(input int a, output logic [7:0] v);
    logic [7:0] rx;
    shift_bits({4'b1000, 4'(a)}, 8, rx);
    shift_bits(8'h00, 8, v);
  endtask

  task automatic rd_stream(output logic [23:0] w);
    logic [7:0] rx, b0, b1, b2;
    shift_bits(8'h40, 8, rx);
    shift_bits(8'h00, 8, b0);
    shift_bits(8'h00, 8, b1);
    shift_bits(8'h00, 8, b2);
    w = {b0, b1, b2};
  endtask

  task automatic strobe(input logic [23:0] w);
    @(negedge clk);
    res_data  = w;
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, rx;
    logic [23:0] w;
    logic any_drive;
    int seed;
    n_chk = 0; n_fail = 0; done = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    seed = $urandom(32'h5EED);
    rst_n = 1'b0; clk_pol = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    res_valid = 1'b0; res_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 drdy_n", 32'(drdy_n), 32'd1);
    check("R1 sdo_oe", 32'(sdo_oe), 32'd0);
    check("R1 cfg_regs zero", 32'(cfg_regs != '0), 32'd0);

    // R3 write and read back, polarity 0
    sel_on();
    check("R2 sdo_oe when selected", 32'(sdo_oe), 32'd1);
    wr_reg(3, 8'hA5);
    rd_reg(3, v);
    check("R3 readback reg3", 32'(v), 32'hA5);
    check("R3 cfg_regs reg3", 32'(cfg_regs[3*8 +: 8]), 32'hA5);
    sel_off();

    // R4 polarity 1
    clk_pol = 1'b1;
    sel_on();
    wr_reg(9, 8'h3C);
    rd_reg(9, v);
    check("R4 pol1 readback reg9", 32'(v), 32'h3C);
    rd_reg(3, v);
    check("R4 pol1 reads pol0 write", 32'(v), 32'hA5);
    sel_off();
    clk_pol = 1'b0;

    // R5 status register
    sel_on();
    wr_reg(0, 8'hFF);
    rd_reg(0, v);
    check("R5 status read no data", 32'(v), 32'(exp_rd(0, 1'b1)));
    check("R5 cfg bit7 ignored", 32'(cfg_regs[7:0]), 32'h7F);
    sel_off();

    // R7 timing of first landing
    strobe(24'h123456);
    check("R7 drdy high after strobe", 32'(drdy_n), 32'd1);
    @(negedge clk);
    check("R7 drdy high second cycle", 32'(drdy_n), 32'd1);
    @(negedge clk);
    check("R7 drdy low after load", 32'(drdy_n), 32'd0);

    sel_on();
    rd_reg(0, v);
    check("R5 status mirrors drdy low", 32'(v), 32'(exp_rd(0, 1'b0)));
    sel_off();

    // R7 rise just before update while a word is unread
    strobe(24'h89ABCD);
    check("R7 drdy rises before update", 32'(drdy_n), 32'd1);
    @(negedge clk);
    @(negedge clk);
    check("R7 drdy falls on second word", 32'(drdy_n), 32'd0);

    // R6 / R8 stream read
    sel_on();
    rd_stream(w);
    check("R6 stream word", 32'(w), 32'h89ABCD);
    check("R8 drdy high after stream", 32'(drdy_n), 32'd1);
    sel_off();

    // R9 hold-off during stream read
    sel_on();
    shift_bits(8'h40, 8, rx);
    shift_bits(8'h00, 8, w[23:16]);
    strobe(24'h5A5A01);
    check("R9 drdy high on strobe mid read", 32'(drdy_n), 32'd1);
    shift_bits(8'h00, 8, w[15:8]);
    shift_bits(8'h00, 8, w[7:0]);
    check("R9 old word intact", 32'(w), 32'h89ABCD);
    check("R9 new word lands after read", 32'(drdy_n), 32'd0);
    rd_stream(w);
    check("R9 new word streamed", 32'(w), 32'h5A5A01);
    sel_off();

    // R11 stream cut short keeps drdy low
    strobe(24'hC0FFEE);
    repeat (4) @(negedge clk);
    sel_on();
    shift_bits(8'h40, 8, rx);
    shift_bits(8'h00, 5, rx);
    sel_off();
    check("R11 aborted stream keeps drdy", 32'(drdy_n), 32'd0);
    sel_on();
    rd_stream(w);
    check("R11 word after abort", 32'(w), 32'hC0FFEE);
    sel_off();

    // R11 cut-off write
    sel_on();
    shift_bits(8'h06, 8, rx);
    shift_bits(8'hFF, 4, rx);
    sel_off();
    sel_on();
    rd_reg(6, v);
    check("R11 aborted write no effect", 32'(v), 32'(model[6]));
    wr_reg(6, 8'h77);
    rd_reg(6, v);
    check("R11 fresh write after abort", 32'(v), 32'h77);
    sel_off();

    // R2 bus activity while deselected
    any_drive = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      sdi = (i < 8) ? (i == 5 || i == 7) : 1'b1;
      repeat (HALF) @(negedge clk);
      if (sdo_oe || sdo) any_drive = 1'b1;
      sclk = ~clk_pol;
      repeat (HALF) @(negedge clk);
      if (sdo_oe || sdo) any_drive = 1'b1;
      sclk = clk_pol;
    end
    check("R2 no drive while deselected", 32'(any_drive), 32'd0);
    sel_on();
    rd_reg(5, v);
    check("R2 deselected write ignored", 32'(v), 32'(model[5]));
    sel_off();

    // R10 three-wire burst, random ops
    sel_on();
    for (int i = 0; i < 40; i++) begin
      int a, op;
      logic [7:0] d;
      a  = 1 + int'($urandom % 15);
      op = int'($urandom % 2);
      d  = 8'($urandom);
      if (op == 0) wr_reg(a, d);
      else begin
        rd_reg(a, v);
        check("R10 burst read", 32'(v), 32'(model[a]));
      end
    end
    strobe(24'h0BEEF0);
    repeat (4) @(negedge clk);
    rd_stream(w);
    check("R10 burst stream", 32'(w), 32'h0BEEF0);
    rd_reg(0, v);
    check("R10 burst status", 32'(v), 32'(exp_rd(0, 1'b1)));
    sel_off();

    // R4 random polarity per transaction
    for (int k = 0; k < 8; k++) begin
      int a;
      logic [7:0] d;
      clk_pol = 1'($urandom);
      a = 1 + int'($urandom % 15);
      d = 8'($urandom);
      sel_on();
      wr_reg(a, d);
      rd_reg(a, v);
      check("R4 random polarity", 32'(v), 32'(d));
      sel_off();
      check("R3 cfg_regs random", 32'(cfg_regs[a*8 +: 8]), 32'(d));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule